// File: doc/BRIEF.md
# Layer-1 Start-up Supervision Timer

This block follows a link as it comes up and stops it from hanging part way. A state tracker moves from standby into a synchronization attempt, then into protocol setup and rate setup, and finally into an established control-and-management (C&M) channel. Each state is reported as a 4-bit status code. A programmable layer-1 timer starts when the start-up procedure begins. It stops for good once the C&M channel is reported up.

If the timer runs out before the channel comes up, a one-cycle expiry pulse forces the tracker back to the synchronization-attempt state. The tracker holds there while the pulse is high. Once the pulse has dropped, start-up retries and the timer counts again from zero. The timer can be disabled, and a timeout of zero also disables expiry, so start-up can finish without supervision.

Top module: `l1_startup_sup`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0, `stat_code_o` is 4'b0000 and `tmr_expired_o` is 0.
- R2: The status code follows the state: standby (`state_o`=0) gives 0000, sync attempt (1) gives 0001, protocol setup (2) gives 0010, rate setup (3) gives 0011, and C&M established (4) gives 1000, which is the only code with bit 3 set.
- R3: `start_i` in standby moves the tracker to sync attempt at the next edge and loads the timer with zero. In any other state `start_i` has no effect, neither on the state nor on when the timer expires.
- R4: If no expiry occurs at that edge, `sync_lock_i` moves the tracker from sync attempt to protocol setup, `proto_done_i` moves it from protocol setup to rate setup, and `cm_up_i` moves it from rate setup to C&M established.
- R5: With `tmr_en_i` high throughout, `tmr_expired_o` rises at exactly the T-th clock edge after the start edge, where T = `timeout_i`.
- R6: `tmr_expired_o` stays high for exactly one cycle.
- R7: The edge that raises `tmr_expired_o` puts the tracker in sync attempt (status 0001). While the flag is high, the tracker stays in sync attempt and ignores the progress inputs. The progress inputs take effect again once the flag is low.
- R8: When the expiry flag drops, the timer reloads from zero. If the channel does not come up, the next expiry occurs T edges after the falling edge.
- R9: Entering C&M established clears and stops the timer. No expiry follows while the tracker stays in that state.
- R10: While `tmr_en_i` is low the count pauses and `tmr_expired_o` cannot rise. When the enable returns, counting resumes from the paused value.
- R11: A `timeout_i` of 0 never produces an expiry.
- R12: If expiry and `cm_up_i` arrive at the same edge, expiry wins: the tracker goes to sync attempt, not to C&M established.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the start-up procedure |
| sync_lock_i | input | 1 | Layer-1 synchronization achieved |
| proto_done_i | input | 1 | Protocol setup finished |
| cm_up_i | input | 1 | C&M channel established |
| tmr_en_i | input | 1 | Layer-1 timer enable |
| timeout_i | input | 32 | Timer limit in clock cycles |
| stat_code_o | output | 4 | Start-up status code |
| tmr_expired_o | output | 1 | One-cycle timer expiry pulse |
| state_o | output | 3 | Current tracker state |

## Verification
The assertions check on every cycle that the expiry pulse lasts one cycle and lands the tracker in sync attempt. They also check that the tracker holds in sync attempt while the pulse is high, that expiry never rises without the enable, that no expiry occurs once the channel is established, and how `start_i` acts in and out of standby. Only the bench scenarios can show the exact expiry latency for each timeout value, reload after expiry, the pause under a dropped enable, the zero-timeout case and the tie between expiry and channel-up. The bench checks these by counting edges against the programmed timeout.

// File: rtl/l1s_pkg.sv
package l1s_pkg;
  localparam int unsigned STAT_W = 4;
  localparam int unsigned ST_W   = 3;

  typedef enum logic [ST_W-1:0] {
    ST_STANDBY = 3'd0,
    ST_SYNC    = 3'd1,
    ST_PROTO   = 3'd2,
    ST_RATE    = 3'd3,
    ST_CM      = 3'd4
  } su_state_e;

  function automatic logic [STAT_W-1:0] stat_of(su_state_e s);
    case (s)
      ST_SYNC:  return 4'b0001;
      ST_PROTO: return 4'b0010;
      ST_RATE:  return 4'b0011;
      ST_CM:    return 4'b1000;
      default:  return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/l1s_timer.sv
module l1s_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             load_i,
  input  logic             stop_i,
  output logic             hit_o,
  output logic             expired_o
);
  logic             run_q;
  logic             exp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc   = cnt_q + CNT_W'(1);
  // limit of zero disables expiry
  assign hit_o     = run_q && en_i && (limit_i != '0) && (cnt_inc == limit_i);
  assign expired_o = exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      exp_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      exp_q <= hit_o;
      if (hit_o) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (exp_q || load_i) begin
        // falling expiry restarts start-up: reload from zero
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (stop_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (run_q && en_i) begin
        cnt_q <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/l1s_tracker.sv
module l1s_tracker
  import l1s_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      sync_lock_i,
  input  logic      proto_done_i,
  input  logic      cm_up_i,
  input  logic      hit_i,
  input  logic      hold_i,
  output su_state_e state_o,
  output logic      load_o,
  output logic      cm_enter_o
);
  su_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    cm_enter_o = 1'b0;
    if (hit_i || hold_i) begin
      // expiry rollback outranks every progress input
      state_d = ST_SYNC;
    end else begin
      case (state_q)
        ST_STANDBY: if (start_i) begin
          state_d = ST_SYNC;
          load_o  = 1'b1;
        end
        ST_SYNC:  if (sync_lock_i)  state_d = ST_PROTO;
        ST_PROTO: if (proto_done_i) state_d = ST_RATE;
        ST_RATE:  if (cm_up_i) begin
          state_d    = ST_CM;
          cm_enter_o = 1'b1;
        end
        ST_CM:    state_d = ST_CM;
        default:  state_d = ST_STANDBY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_STANDBY;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/l1_startup_sup.sv
module l1_startup_sup
  import l1s_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sync_lock_i,
  input  logic              proto_done_i,
  input  logic              cm_up_i,
  input  logic              tmr_en_i,
  input  logic [CNT_W-1:0]  timeout_i,
  output logic [STAT_W-1:0] stat_code_o,
  output logic              tmr_expired_o,
  output logic [ST_W-1:0]   state_o
);
  su_state_e state;
  logic      hit, expired, load, cm_enter;

  l1s_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tmr_en_i),
    .limit_i   (timeout_i),
    .load_i    (load),
    .stop_i    (cm_enter),
    .hit_o     (hit),
    .expired_o (expired)
  );

  l1s_tracker u_tracker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .sync_lock_i  (sync_lock_i),
    .proto_done_i (proto_done_i),
    .cm_up_i      (cm_up_i),
    .hit_i        (hit),
    .hold_i       (expired),
    .state_o      (state),
    .load_o       (load),
    .cm_enter_o   (cm_enter)
  );

  assign stat_code_o   = stat_of(state);
  assign tmr_expired_o = expired;
  assign state_o       = state;
endmodule

// File: rtl/l1_startup_sup_chk.sv
module l1_startup_sup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       tmr_en_i,
  input logic [3:0] stat_code_o,
  input logic       tmr_expired_o,
  input logic [2:0] state_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (state_o == 3'd0 && stat_code_o == 4'b0000 && !tmr_expired_o)
        else $error("reset state wrong");
    end
  end

  // R6
  exp_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_expired_o |=> !tmr_expired_o);

  // R7
  exp_rollback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_expired_o) |-> (state_o == 3'd1 && stat_code_o == 4'b0001));

  // R7
  exp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_expired_o |=> state_o == 3'd1);

  // R10
  exp_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_expired_o) |-> $past(tmr_en_i));

  // R9
  no_exp_in_cm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_code_o[3] |-> !tmr_expired_o);

  // R3
  start_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && start_i) |=> state_o == 3'd1);

  // R3
  no_fall_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'd0) |=> state_o != 3'd0);
endmodule

bind l1_startup_sup l1_startup_sup_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .tmr_en_i      (tmr_en_i),
  .stat_code_o   (stat_code_o),
  .tmr_expired_o (tmr_expired_o),
  .state_o       (state_o)
);

// File: tb/l1_startup_sup_tb_top.sv
module l1_startup_sup_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        sync_lock_i = 1'b0;
  logic        proto_done_i = 1'b0;
  logic        cm_up_i = 1'b0;
  logic        tmr_en_i = 1'b0;
  logic [31:0] timeout_i = '0;
  logic [3:0]  stat_code_o;
  logic        tmr_expired_o;
  logic [2:0]  state_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk_i = ~clk_i;

  l1_startup_sup dut_i (
    .clk_i, .rst_ni, .start_i, .sync_lock_i, .proto_done_i, .cm_up_i,
    .tmr_en_i, .timeout_i, .stat_code_o, .tmr_expired_o, .state_o
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    start_i = 0; sync_lock_i = 0; proto_done_i = 0; cm_up_i = 0;
    tmr_en_i = 1'b1; timeout_i = '0;
    step(); step();
    rst_ni = 1'b1;
  endtask

  task automatic watch_no_exp(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (tmr_expired_o) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1
    rst_ni = 1'b0;
    step();
    chk(state_o == 0 && stat_code_o == 0 && !tmr_expired_o, "R1", int'(state_o), 0);

    // R5 R6 R8: sweep timeout 1..6
    for (int t = 1; t <= 6; t++) begin
      do_reset();
      timeout_i = t;
      start_i = 1; step(); start_i = 0;
      chk(state_o == 1 && stat_code_o == 4'b0001, "R3", int'(stat_code_o), 1);
      for (int k = 1; k <= t; k++) begin
        step();
        chk(tmr_expired_o == (k == t), "R5", int'(tmr_expired_o), int'(k == t));
      end
      chk(state_o == 1 && stat_code_o == 4'b0001, "R7", int'(stat_code_o), 1);
      step();
      chk(!tmr_expired_o, "R6", int'(tmr_expired_o), 0);
      for (int k = 1; k <= t; k++) begin
        step();
        chk(tmr_expired_o == (k == t), "R8", int'(tmr_expired_o), int'(k == t));
      end
    end

    // R3: start_i held high after entry does not reload the timer
    do_reset();
    timeout_i = 4;
    start_i = 1;
    for (int k = 0; k <= 4; k++) begin
      step();
      if (k >= 1) chk(tmr_expired_o == (k == 4), "R3", int'(tmr_expired_o), int'(k == 4));
    end
    start_i = 0;

    // R2 R4 R7: progress, expiry rollback, hold, resume
    do_reset();
    timeout_i = 5;
    start_i = 1; step(); start_i = 0;
    sync_lock_i = 1; step(); sync_lock_i = 0;
    chk(state_o == 2 && stat_code_o == 4'b0010, "R2", int'(stat_code_o), 2);
    proto_done_i = 1; step(); proto_done_i = 0;
    chk(state_o == 3 && stat_code_o == 4'b0011, "R4", int'(stat_code_o), 3);
    step(); step();
    chk(!tmr_expired_o && state_o == 3, "R5", int'(state_o), 3);
    step();
    chk(tmr_expired_o && state_o == 1 && stat_code_o == 4'b0001, "R7", int'(stat_code_o), 1);
    sync_lock_i = 1; step();
    chk(state_o == 1 && !tmr_expired_o, "R7", int'(state_o), 1);
    step(); sync_lock_i = 0;
    chk(state_o == 2, "R7", int'(state_o), 2);

    // R3 R4 R9 R2: start ignored outside standby, reach C&M, timer stopped
    do_reset();
    timeout_i = 10;
    start_i = 1; step(); start_i = 0;
    sync_lock_i = 1; step(); sync_lock_i = 0;
    start_i = 1; step(); start_i = 0;
    chk(state_o == 2, "R3", int'(state_o), 2);
    proto_done_i = 1; step(); proto_done_i = 0;
    cm_up_i = 1; step(); cm_up_i = 0;
    chk(state_o == 4 && stat_code_o == 4'b1000, "R4", int'(stat_code_o), 8);
    watch_no_exp(30, "R9");
    chk(state_o == 4 && stat_code_o[3], "R9", int'(state_o), 4);

    // R12: expiry and cm_up on the same edge
    do_reset();
    timeout_i = 4;
    start_i = 1; step(); start_i = 0;
    sync_lock_i = 1; step(); sync_lock_i = 0;
    proto_done_i = 1; step(); proto_done_i = 0;
    step();
    cm_up_i = 1; step(); cm_up_i = 0;
    chk(state_o == 1 && tmr_expired_o, "R12", int'(state_o), 1);

    // R10: disabled holds expiry low, pause and resume
    do_reset();
    timeout_i = 3; tmr_en_i = 0;
    start_i = 1; step(); start_i = 0;
    watch_no_exp(20, "R10");
    tmr_en_i = 1; step(); step();
    chk(!tmr_expired_o, "R10", int'(tmr_expired_o), 0);
    tmr_en_i = 0;
    watch_no_exp(5, "R10");
    tmr_en_i = 1; step();
    chk(tmr_expired_o, "R10", int'(tmr_expired_o), 1);

    // R11: zero timeout
    do_reset();
    timeout_i = 0;
    start_i = 1; step(); start_i = 0;
    watch_no_exp(40, "R11");
    chk(state_o == 1, "R11", int'(state_o), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule